// File: doc/BRIEF.md
# Burst SRAM Data Path with Selectable Read Latency

This block models the data side of a small synchronous burst SRAM. It receives a selected-cycle flag, address-load and advance controls, write controls and write data from a sequencer. It keeps a burst address whose two low bits can step, and it performs reads and byte-lane writes on an array that is split into lanes. Read data leaves on a zero-when-idle output bus. A driving flag and a driver-enable flag come with it.

A mode input picks the read latency. In flow-through mode the data of a read sampled at one rising edge is presented right after that edge. In pipelined mode it passes through one more output register and appears after the next edge. Deselect cycles travel through the same stages as reads, so in pipelined mode the drivers stay on for a full cycle after a deselect is sampled. An asynchronous disable input can turn the drivers off at any moment. It cannot turn them on when no read result is pending.

Top module: `burst_sram_dp`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `rd_active` and `drv_on` are 0 and `rdata` is 0.
- R2: With `pipe_en` = 0, a read sampled at edge k sets `rd_active` = 1 and presents the addressed word on `rdata` right after edge k. A deselect sampled at edge k+1 clears the output right after edge k+1.
- R3: With `pipe_en` = 1, a read sampled at edge k appears only after edge k+1. Back-to-back reads then deliver their words on consecutive cycles.
- R4: With `pipe_en` = 1, a deselect (`cs` = 0) sampled at edge k+1 after a read at edge k leaves the output driven after edge k+1. It turns the output off only after edge k+2.
- R5: In a selected cycle without `ld_ro`, `all_wr_n` = 0 writes all four 8-bit lanes, whatever `lane_wr_n` and `lane_sel_n` are.
- R6: With `all_wr_n` = 1 and `lane_wr_n` = 0, only lanes whose `lane_sel_n` bit is 0 are written. Bit i covers `wdata[8i+7:8i]`. With both at 1, the cycle is a read and the array is unchanged.
- R7: A cycle with `ld_ro` = 1 is a read that leaves the array unchanged, whatever the write controls are.
- R8: A write cycle produces no output: `rd_active` = 0 and `rdata` = 0 in its output slot. Reads drive all 32 bits whatever `lane_sel_n` holds.
- R9: `drv_off` = 1 forces `drv_on` = 0 and `rdata` = 0 without waiting for a clock edge. Lowering it re-enables an output that is still pending, without a clock edge. `drv_on` is never 1 while `rd_active` is 0.
- R10: In a selected cycle, `ld` or `ld_ro` uses `addr`. Otherwise `adv` = 1 adds one to the two low address bits, wrapping from 3 back to 0, and `adv` = 0 reuses the current address. Deselects hold it.
- R11: A read made with `drv_off` = 1 still updates the burst address, so a following advance reads the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_en | input | 1 | 1 = pipelined reads, 0 = flow-through reads |
| cs | input | 1 | Cycle selected; 0 = deselect |
| ld | input | 1 | Load `addr` as new burst address |
| ld_ro | input | 1 | Load `addr`, cycle forced to read |
| adv | input | 1 | Step the burst address when not loading |
| addr | input | 4 | External word address |
| all_wr_n | input | 1 | Write all lanes, active low |
| lane_wr_n | input | 1 | Write selected lanes, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| wdata | input | 32 | Write data |
| drv_off | input | 1 | Asynchronous driver disable, active high |
| rdata | output | 32 | Read data, 0 when not driven |
| rd_active | output | 1 | A read result occupies the output slot |
| drv_on | output | 1 | Output drivers enabled |

## Verification
A burst address that is stepped wrongly or not held shows up as a wrong word on the very next read output. That is one cycle after the edge in flow-through mode and two in pipelined mode. A stage flag that is off by one register shows up as `rd_active` rising or falling a cycle early or late around a deselect. A bad lane decode is seen on the read-back of the written word. The gating of the disable input is checked without any clock edge between the input change and the sample.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_addr_gen.sv
`timescale 1ns/1ps
module sram_addr_gen #(
  parameter int AW = 4,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] cur_q;
  logic [BB-1:0] nxt_lo;

  assign nxt_lo = cur_q[BB-1:0] + BB'(1);

  always_comb begin
    if (load)     eff_addr = ext_addr;
    else if (adv) eff_addr = {cur_q[AW-1:BB], nxt_lo};
    else          eff_addr = cur_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          cur_q <= '0;
    else if (step_en) cur_q <= eff_addr;
  end
endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array #(
  parameter int LANES = 4,
  parameter int LW    = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [AW-1:0]       addr,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q_r;
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LW +: LW];
      q_r <= mem[addr];
    end
    assign q[g*LW +: LW] = q_r;
  end
endmodule

// File: rtl/sram_out_pipe.sv
`timescale 1ns/1ps
module sram_out_pipe #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pipe_en,
  input  logic          act_in,
  input  logic [DW-1:0] mem_q,
  output logic          act_out,
  output logic [DW-1:0] data_out
);
  logic          s1_act, s2_act;
  logic [DW-1:0] s2_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_act <= 1'b0;
      s2_act <= 1'b0;
    end else begin
      s1_act <= act_in;
      s2_act <= s1_act;
    end
    s2_data <= mem_q;
  end

  assign act_out  = pipe_en ? s2_act  : s1_act;
  assign data_out = pipe_en ? s2_data : mem_q;
endmodule

// File: rtl/burst_sram_dp.sv
`timescale 1ns/1ps
module burst_sram_dp #(
  parameter int LANES = 4,
  parameter int LW    = 8,
  parameter int DEPTH = 16,
  parameter int BB    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pipe_en,
  input  logic                       cs,
  input  logic                       ld,
  input  logic                       ld_ro,
  input  logic                       adv,
  input  logic [$clog2(DEPTH)-1:0]   addr,
  input  logic                       all_wr_n,
  input  logic                       lane_wr_n,
  input  logic [LANES-1:0]           lane_sel_n,
  input  logic [LANES*LW-1:0]        wdata,
  input  logic                       drv_off,
  output logic [LANES*LW-1:0]        rdata,
  output logic                       rd_active,
  output logic                       drv_on
);
  import bsram_pkg::*;

  localparam int AW = $clog2(DEPTH);
  localparam int DW = LANES * LW;

  op_e             op;
  logic            wr_req;
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]   eff_addr;
  logic [DW-1:0]   mem_q;
  logic [DW-1:0]   pipe_data;

  assign wr_req = ~ld_ro & (~all_wr_n | ~lane_wr_n);

  always_comb begin
    if (!cs)        op = OP_IDLE;
    else if (wr_req) op = OP_WRITE;
    else            op = OP_READ;
  end

  always_comb begin
    if (op != OP_WRITE) lane_we = '0;
    else if (!all_wr_n) lane_we = '1;
    else                lane_we = ~lane_sel_n;
  end

  sram_addr_gen #(.AW(AW), .BB(BB)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .step_en  (cs),
    .load     (ld | ld_ro),
    .adv      (adv),
    .ext_addr (addr),
    .eff_addr (eff_addr)
  );

  sram_lane_array #(.LANES(LANES), .LW(LW), .DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk   (clk),
    .we    (lane_we),
    .addr  (eff_addr),
    .wdata (wdata),
    .q     (mem_q)
  );

  sram_out_pipe #(.DW(DW)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .pipe_en  (pipe_en),
    .act_in   (op == OP_READ),
    .mem_q    (mem_q),
    .act_out  (rd_active),
    .data_out (pipe_data)
  );

  assign drv_on = rd_active & ~drv_off;
  assign rdata  = drv_on ? pipe_data : '0;
endmodule

// File: rtl/burst_sram_dp_chk.sv
`timescale 1ns/1ps
module burst_sram_dp_chk (
  input logic clk,
  input logic rst,
  input logic pipe_en,
  input logic cs,
  input logic ld_ro,
  input logic all_wr_n,
  input logic lane_wr_n,
  input logic drv_off,
  input logic rd_active,
  input logic drv_on
);
  logic wr_cyc, rd_cyc;
  assign wr_cyc = cs & ~ld_ro & (~all_wr_n | ~lane_wr_n);
  assign rd_cyc = cs & ~wr_cyc;

  // R1
  a_r1_reset_idle: assert property (@(posedge clk) rst |=> (!rd_active && !drv_on));

  // R2
  a_r2_ft_read: assert property (@(posedge clk) disable iff (rst)
    (!pipe_en && rd_cyc) |=> (pipe_en || rd_active));

  // R3
  a_r3_pipe_read: assert property (@(posedge clk) disable iff (rst)
    (pipe_en && rd_cyc) ##1 pipe_en |=> rd_active);

  // R4
  a_r4_dcd_off: assert property (@(posedge clk) disable iff (rst)
    (pipe_en && !cs) ##1 (pipe_en && !cs) |=> !rd_active);

  // R7
  a_r7_ro_reads: assert property (@(posedge clk) disable iff (rst)
    (!pipe_en && cs && ld_ro) |=> (pipe_en || rd_active));

  // R8
  a_r8_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (!pipe_en && wr_cyc) |=> (pipe_en || !rd_active));

  // R9
  a_r9_drive_needs_active: assert property (@(posedge clk) disable iff (rst)
    drv_on |-> rd_active);

  always_comb begin
    if (!rst) begin
      a_r9_off_wins: assert (!(drv_off && drv_on));
    end
  end
endmodule

bind burst_sram_dp burst_sram_dp_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .pipe_en   (pipe_en),
  .cs        (cs),
  .ld_ro     (ld_ro),
  .all_wr_n  (all_wr_n),
  .lane_wr_n (lane_wr_n),
  .drv_off   (drv_off),
  .rd_active (rd_active),
  .drv_on    (drv_on)
);

// File: tb/burst_sram_dp_tb.sv
`timescale 1ns/1ps
module burst_sram_dp_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        pipe_en, cs, ld, ld_ro, adv, all_wr_n, lane_wr_n, drv_off;
  logic [3:0]  addr, lane_sel_n;
  logic [31:0] wdata, rdata;
  logic        rd_active, drv_on;
  logic [31:0] shadow [16];
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  burst_sram_dp u_dut (
    .clk(clk), .rst(rst), .pipe_en(pipe_en), .cs(cs), .ld(ld), .ld_ro(ld_ro),
    .adv(adv), .addr(addr), .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n),
    .lane_sel_n(lane_sel_n), .wdata(wdata), .drv_off(drv_off),
    .rdata(rdata), .rd_active(rd_active), .drv_on(drv_on)
  );

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_in();
    cs = 0; ld = 0; ld_ro = 0; adv = 0; all_wr_n = 1; lane_wr_n = 1;
    lane_sel_n = 4'hF; wdata = '0;
  endtask

  task automatic settle();
    idle_in();
    tick();
    tick();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d,
                    input logic an, input logic ln, input logic [3:0] sn);
    pipe_en = 0; cs = 1; ld = 1; addr = a; wdata = d;
    all_wr_n = an; lane_wr_n = ln; lane_sel_n = sn;
    tick();
    chk("R8 write slot rd_active", {31'd0, rd_active}, 32'd0);
    chk("R8 write slot rdata", rdata, 32'd0);
    if (!an) shadow[a] = d;
    else if (!ln)
      for (int i = 0; i < 4; i++)
        if (!sn[i]) shadow[a][i*8 +: 8] = d[i*8 +: 8];
    idle_in();
  endtask

  task automatic rd_ft(input logic [3:0] a, input string tag);
    pipe_en = 0; cs = 1; ld = 1; addr = a; lane_sel_n = 4'b0110;
    tick();
    chk({tag, " ft read active"}, {31'd0, rd_active}, 32'd1);
    chk({tag, " ft read data"}, rdata, shadow[a]);
    idle_in();
    tick();
    chk("R2 ft deselect off", {31'd0, rd_active}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 reset rd_active", {31'd0, rd_active}, 32'd0);
    chk("R1 reset drv_on", {31'd0, drv_on}, 32'd0);
    chk("R1 reset rdata", rdata, 32'd0);
  endtask

  task automatic t_global_write();
    wr(4'd3, 32'hA5A5_1234, 1'b0, 1'b1, 4'hF);
    rd_ft(4'd3, "R5");
    wr(4'd9, 32'h0BAD_CAFE, 1'b0, 1'b0, 4'b1110);
    rd_ft(4'd9, "R5 lanes ignored");
  endtask

  task automatic t_byte_write();
    wr(4'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, 4'b1010);
    chk("R6 lane merge model", shadow[3], 32'hA5FF_12FF);
    rd_ft(4'd3, "R6");
    pipe_en = 0; cs = 1; ld = 1; addr = 4'd3; wdata = 32'h0;
    all_wr_n = 1; lane_wr_n = 1; lane_sel_n = 4'b0000;
    tick();
    chk("R6 both high is read", rdata, 32'hA5FF_12FF);
    idle_in();
    tick();
    rd_ft(4'd3, "R6 unchanged");
  endtask

  task automatic t_ro_strobe();
    pipe_en = 0; cs = 1; ld_ro = 1; addr = 4'd3; wdata = 32'h0;
    all_wr_n = 0; lane_wr_n = 0; lane_sel_n = 4'b0000;
    tick();
    chk("R7 ro cycle active", {31'd0, rd_active}, 32'd1);
    chk("R7 ro cycle data", rdata, shadow[3]);
    idle_in();
    tick();
    rd_ft(4'd3, "R7 array unchanged");
  endtask

  task automatic t_pipe();
    settle();
    pipe_en = 1; cs = 1; ld = 1; addr = 4'd3;
    tick();
    chk("R3 pipe not yet", {31'd0, rd_active}, 32'd0);
    ld = 1; addr = 4'd9;
    tick();
    chk("R3 pipe first word", rdata, shadow[3]);
    idle_in();
    tick();
    chk("R3 pipe second word", rdata, shadow[9]);
    chk("R4 still driven after deselect", {31'd0, rd_active}, 32'd1);
    tick();
    chk("R4 off after second edge", {31'd0, rd_active}, 32'd0);
    chk("R4 rdata zero", rdata, 32'd0);
  endtask

  task automatic t_burst();
    settle();
    for (int i = 4; i < 8; i++) wr(4'(i), 32'h1000_0000 * i + 32'(i) * 32'h11, 1'b0, 1'b1, 4'hF);
    pipe_en = 0; cs = 1; ld = 1; addr = 4'd6;
    tick();
    chk("R10 load word", rdata, shadow[6]);
    ld = 0; adv = 1;
    tick();
    chk("R10 step to 7", rdata, shadow[7]);
    tick();
    chk("R10 wrap to 4", rdata, shadow[4]);
    tick();
    chk("R10 step to 5", rdata, shadow[5]);
    adv = 0;
    tick();
    chk("R10 hold on no advance", rdata, shadow[5]);
    idle_in();
    tick();
    cs = 1; adv = 1;
    tick();
    chk("R10 deselect held address", rdata, shadow[6]);
    idle_in();
    tick();
  endtask

  task automatic t_drv_off();
    settle();
    pipe_en = 1; cs = 1; ld = 1; addr = 4'd6; drv_off = 1;
    tick();
    idle_in();
    tick();
    chk("R9 pending active", {31'd0, rd_active}, 32'd1);
    chk("R9 disabled drv_on", {31'd0, drv_on}, 32'd0);
    chk("R9 disabled rdata", rdata, 32'd0);
    drv_off = 0;
    #1;
    chk("R9 async enable drv_on", {31'd0, drv_on}, 32'd1);
    chk("R9 async enable rdata", rdata, shadow[6]);
    tick();
    chk("R9 no enable when idle", {31'd0, drv_on}, 32'd0);
  endtask

  task automatic t_dummy();
    settle();
    pipe_en = 0; cs = 1; ld = 1; addr = 4'd4; drv_off = 1;
    tick();
    chk("R11 dummy read hidden", rdata, 32'd0);
    ld = 0; adv = 1; drv_off = 0;
    tick();
    chk("R11 next word after dummy", rdata, shadow[5]);
    idle_in();
    tick();
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    rst = 1; pipe_en = 0; drv_off = 0; addr = '0;
    idle_in();
    tick();
    tick();
    t_reset();
    rst = 0;
    tick();
    t_reset();
    t_global_write();
    t_byte_write();
    t_ro_strobe();
    t_pipe();
    t_burst();
    t_drv_off();
    t_dummy();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule